// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it takes a raw 8-bit opcode, the accumulator, one operand byte, the current flag set and two 16-bit values: the HL pair and a second register pair. One clock edge later it presents the new accumulator, the new flags and the new HL value. An internal decoder maps the opcode onto an operation, so the surrounding core only has to present the right operand byte: the source register for register forms, or the byte after the opcode for immediate forms.

The unit covers three groups. The first is eight accumulator/operand operations: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. The second is the operations on the accumulator and carry that take no operand: two 8-bit rotates, two 9-bit rotates through carry, complement, set carry, complement carry and decimal adjust. The third is a 16-bit add of a register pair into HL. Any opcode outside these groups passes the accumulator, flags and HL through unchanged, which keeps the unit's outputs valid for every instruction.

Top module: `acc_alu_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next acc_out, flags_out and hl_out are all zero. Flags are packed as bit 4 sign, bit 3 zero, bit 2 auxiliary carry (AC), bit 1 parity, bit 0 carry (CY).
- R2: Opcodes 0x80 to 0xBF are register forms. Bits 5:3 select the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare. When bits 2:0 equal 7, the operand is acc_in and operand_in is ignored. Otherwise the operand is operand_in.
- R3: Opcodes 0xC6, 0xCE, 0xD6, 0xDE, 0xE6, 0xEE, 0xF6 and 0xFE perform the same eight operations, in the same order, with operand_in as the operand.
- R4: Add gives A+B and add with carry gives A+B+CY. CY is the carry out of bit 7 and AC is the carry out of bit 3. Plain add ignores the incoming CY.
- R5: Subtract gives A-B and subtract with borrow gives A-B-CY. CY is set exactly when B plus the borrow-in exceeds A. AC is the carry out of bit 3 of A + ~B + (1 - borrow-in).
- R6: Compare (register form and 0xFE) sets the flags exactly as a subtract would, but leaves the accumulator unchanged.
- R7: AND, XOR and OR always clear CY. AND sets AC to bit 3 of (A OR B). XOR and OR clear AC.
- R8: For every accumulator/operand operation and for decimal adjust, the sign flag is bit 7 of the result, zero is set when the result is 0x00, and parity is set when the result has an even number of one bits.
- R9: 0x07 rotates the accumulator left by one and 0x0F rotates it right by one. In both cases the bit that wraps around is copied into CY. No other flag changes.
- R10: 0x17 rotates the 9-bit value {CY, A} left and 0x1F rotates it right. No other flag changes.
- R11: 0x2F inverts the accumulator and changes no flag. 0x37 sets CY. 0x3F inverts CY. These two leave the accumulator and the other flags as they were.
- R12: 0x27 (decimal adjust) first adds 0x06 when A's low nibble exceeds 9 or AC is set. AC becomes the carry out of bit 3 of that step. It then adds 0x60 when the adjusted high nibble exceeds 9, when CY is set, or when the first step carried out of bit 7. CY is set when this second step applies and otherwise keeps its old value.
- R13: 0x09, 0x19 and 0x39 add pair_in into HL, while 0x29 adds HL to itself and ignores pair_in. The sum is unsigned modulo 2^16, CY is set to the carry out of bit 15, and the accumulator and the other flags are unchanged.
- R14: Results appear one clock edge after the inputs. Every opcode not listed above leaves the accumulator, flags and HL unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 8 | Instruction opcode |
| acc_in | input | 8 | Current accumulator |
| operand_in | input | 8 | Source register value or immediate byte |
| flags_in | input | 5 | Current flags {S, Z, AC, P, CY} |
| pair_in | input | 16 | Register pair for the 16-bit add |
| hl_in | input | 16 | Current HL pair |
| acc_out | output | 8 | New accumulator |
| flags_out | output | 5 | New flags {S, Z, AC, P, CY} |
| hl_out | output | 16 | New HL pair |

## Verification
A hand-computed vector table shows the effect of each operation class on the flags. The vectors include a carry out of both nibbles into a zero result, a borrow whose auxiliary carry still sets, an incoming carry that the logical group must clear, and a rotate through carry that must leave the upper flags alone. Every one of the 256 opcodes is then run against a model in the bench. The accumulator takes the values 0x00, 0xFF, 0x80 and 0x99 as well as random bytes, and random operands and flags are used, which separates the register, immediate and passthrough decodes. Directed cases cover the HL-doubling form of the 16-bit add, where pair_in must be ignored, the case where the source field selects the accumulator, and decimal adjust with an incoming carry and on an already valid BCD value.

// File: rtl/acc_alu_pkg.sv
// Package: shared widths, flag positions, operation codes and the
// flag-building helper for the accumulator ALU.
// Assumes an 8-bit accumulator and a 16-bit register pair.
package acc_alu_pkg;
    localparam int ACC_W  = 8;
    localparam int PAIR_W = 16;
    localparam int FLAG_W = 5;
    localparam int NIB_W  = ACC_W / 2;

    // Flag bit positions inside the packed flag vector
    localparam int F_CY = 0;
    localparam int F_P  = 1;
    localparam int F_AC = 2;
    localparam int F_Z  = 3;
    localparam int F_S  = 4;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_ANA  = 5'd4,
        OP_XRA  = 5'd5,
        OP_ORA  = 5'd6,
        OP_CMP  = 5'd7,
        OP_RLC  = 5'd8,
        OP_RRC  = 5'd9,
        OP_RAL  = 5'd10,
        OP_RAR  = 5'd11,
        OP_CMA  = 5'd12,
        OP_STC  = 5'd13,
        OP_CMC  = 5'd14,
        OP_DAA  = 5'd15,
        OP_DAD  = 5'd16,
        OP_PASS = 5'd17
    } alu_op_e;

    // Build sign, zero and parity from a result; AC and CY are supplied
    function automatic logic [FLAG_W-1:0] mk_flags(
        input logic [ACC_W-1:0] res,
        input logic             ac,
        input logic             cy
    );
        logic [FLAG_W-1:0] f;
        f       = '0;
        f[F_S]  = res[ACC_W-1];
        f[F_Z]  = (res == '0);
        f[F_AC] = ac;
        f[F_P]  = ~^res;
        f[F_CY] = cy;
        return f;
    endfunction
endpackage

// File: rtl/acc_alu_decode.sv
// Module: acc_alu_decode
// Maps a raw opcode onto an ALU operation. It also reports whether the
// register source field names the accumulator, and whether the 16-bit
// add names HL as its own addend. Purely combinational.
// Assumes the opcode layout given in the brief; unknown codes give OP_PASS.
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [ACC_W-1:0] opcode,
    output alu_op_e          op,
    output logic             src_is_acc,
    output logic             pair_is_hl
);
    localparam logic [2:0] SRC_ACC  = 3'b111;
    localparam logic [2:0] IMM_LOW  = 3'b110;
    localparam logic [2:0] ACCOP_LO = 3'b111;
    localparam logic [3:0] DAD_LO   = 4'h9;
    localparam logic [1:0] HL_SEL   = 2'b10;

    logic [2:0] mid;
    assign mid = opcode[5:3];

    // Classify the opcode by its top two bits and low field
    always_comb begin
        op         = OP_PASS;
        src_is_acc = 1'b0;
        pair_is_hl = 1'b0;
        if (opcode[7:6] == 2'b10) begin
            op         = alu_op_e'({2'b00, mid});
            src_is_acc = (opcode[2:0] == SRC_ACC);
        end else if (opcode[7:6] == 2'b11 && opcode[2:0] == IMM_LOW) begin
            op = alu_op_e'({2'b00, mid});
        end else if (opcode[7:6] == 2'b00 && opcode[2:0] == ACCOP_LO) begin
            case (mid)
                3'd0:    op = OP_RLC;
                3'd1:    op = OP_RRC;
                3'd2:    op = OP_RAL;
                3'd3:    op = OP_RAR;
                3'd4:    op = OP_DAA;
                3'd5:    op = OP_CMA;
                3'd6:    op = OP_STC;
                default: op = OP_CMC;
            endcase
        end else if (opcode[7:6] == 2'b00 && opcode[3:0] == DAD_LO) begin
            op         = OP_DAD;
            pair_is_hl = (opcode[5:4] == HL_SEL);
        end
    end
endmodule

// File: rtl/acc_alu_byte_core.sv
// Module: acc_alu_byte_core
// Combinational 8-bit datapath: the add/subtract/logic group, rotates,
// complement, carry operations and decimal adjust. For OP_DAD and OP_PASS
// the accumulator and flags pass through; the 16-bit add sits elsewhere.
// Assumes the operand has already been chosen (register, immediate or A).
module acc_alu_byte_core
    import acc_alu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [ACC_W-1:0]  a,
    input  logic [ACC_W-1:0]  b,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [ACC_W-1:0]  r_acc,
    output logic [FLAG_W-1:0] r_flags
);
    localparam logic [NIB_W-1:0] BCD_MAX = NIB_W'(9);
    localparam logic [NIB_W-1:0] LO_CARRY = NIB_W'(10);
    localparam logic [ACC_W:0]   LO_ADJ  = (ACC_W+1)'(6);
    localparam logic [ACC_W-1:0] HI_ADJ  = ACC_W'(8'h60);

    logic             cy;
    logic             carry_in;
    logic [ACC_W:0]   sum_w;
    logic [NIB_W:0]   nib_w;
    logic [ACC_W-1:0] b_eff;
    logic             is_sub;
    logic             lo_fix, hi_fix, daa_ac;
    logic [ACC_W:0]   daa_lo;
    logic [ACC_W-1:0] daa_res;
    logic [ACC_W-1:0] logic_res;

    assign cy = flags_in[F_CY];

    // Shared adder: subtraction adds the inverted operand with carry-in
    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        b_eff    = is_sub ? ~b : b;
        carry_in = 1'b0;
        if (op == OP_ADC)       carry_in = cy;
        else if (op == OP_SBB)  carry_in = ~cy;
        else if (is_sub)        carry_in = 1'b1;
        sum_w = {1'b0, a} + {1'b0, b_eff} + {{ACC_W{1'b0}}, carry_in};
        nib_w = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
              + {{NIB_W{1'b0}}, carry_in};
    end

    // Two-step decimal adjust chain
    always_comb begin
        lo_fix  = (a[NIB_W-1:0] > BCD_MAX) || flags_in[F_AC];
        daa_ac  = lo_fix && (a[NIB_W-1:0] >= LO_CARRY);
        daa_lo  = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
        hi_fix  = (daa_lo[ACC_W-1:NIB_W] > BCD_MAX) || cy || daa_lo[ACC_W];
        daa_res = daa_lo[ACC_W-1:0] + (hi_fix ? HI_ADJ : '0);
    end

    // Bitwise logic results
    always_comb begin
        case (op)
            OP_ANA:  logic_res = a & b;
            OP_XRA:  logic_res = a ^ b;
            default: logic_res = a | b;
        endcase
    end

    // Select the result and flags for the operation
    always_comb begin
        r_acc   = a;
        r_flags = flags_in;
        case (op)
            OP_ADD, OP_ADC: begin
                r_acc   = sum_w[ACC_W-1:0];
                r_flags = mk_flags(sum_w[ACC_W-1:0], nib_w[NIB_W], sum_w[ACC_W]);
            end
            OP_SUB, OP_SBB: begin
                r_acc   = sum_w[ACC_W-1:0];
                r_flags = mk_flags(sum_w[ACC_W-1:0], nib_w[NIB_W], ~sum_w[ACC_W]);
            end
            OP_CMP: begin
                r_flags = mk_flags(sum_w[ACC_W-1:0], nib_w[NIB_W], ~sum_w[ACC_W]);
            end
            OP_ANA: begin
                r_acc   = logic_res;
                r_flags = mk_flags(logic_res, a[NIB_W-1] | b[NIB_W-1], 1'b0);
            end
            OP_XRA, OP_ORA: begin
                r_acc   = logic_res;
                r_flags = mk_flags(logic_res, 1'b0, 1'b0);
            end
            OP_RLC: begin
                r_acc         = {a[ACC_W-2:0], a[ACC_W-1]};
                r_flags[F_CY] = a[ACC_W-1];
            end
            OP_RRC: begin
                r_acc         = {a[0], a[ACC_W-1:1]};
                r_flags[F_CY] = a[0];
            end
            OP_RAL: begin
                r_acc         = {a[ACC_W-2:0], cy};
                r_flags[F_CY] = a[ACC_W-1];
            end
            OP_RAR: begin
                r_acc         = {cy, a[ACC_W-1:1]};
                r_flags[F_CY] = a[0];
            end
            OP_CMA:  r_acc         = ~a;
            OP_STC:  r_flags[F_CY] = 1'b1;
            OP_CMC:  r_flags[F_CY] = ~cy;
            OP_DAA: begin
                r_acc   = daa_res;
                r_flags = mk_flags(daa_res, daa_ac, cy | hi_fix);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_pair_add.sv
// Module: acc_alu_pair_add
// Unsigned add of two register pairs with the carry out of the top bit.
// Built as a ripple of nibble-wide slices so the carry path is explicit.
// Assumes PAIR_W is a multiple of NIB_W.
module acc_alu_pair_add
    import acc_alu_pkg::*;
(
    input  logic [PAIR_W-1:0] x,
    input  logic [PAIR_W-1:0] y,
    output logic [PAIR_W-1:0] sum,
    output logic              carry
);
    localparam int SLICES = PAIR_W / NIB_W;

    logic [SLICES:0] c;
    assign c[0]  = 1'b0;
    assign carry = c[SLICES];

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        logic [NIB_W:0] part;
        // One nibble slice of the ripple adder
        always_comb begin
            part = {1'b0, x[g*NIB_W +: NIB_W]} + {1'b0, y[g*NIB_W +: NIB_W]}
                 + {{NIB_W{1'b0}}, c[g]};
        end
        assign sum[g*NIB_W +: NIB_W] = part[NIB_W-1:0];
        assign c[g+1]                = part[NIB_W];
    end
endmodule

// File: rtl/acc_alu_unit.sv
// Module: acc_alu_unit (top)
// Registered accumulator ALU. Decodes the opcode, picks the operand,
// runs the 8-bit core and the 16-bit pair adder, and registers the new
// accumulator, flags and HL on the rising edge. Latency is one cycle.
// Assumes the caller presents the source register or immediate byte on
// operand_in and the addressed pair on pair_in.
module acc_alu_unit
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  opcode,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [ACC_W-1:0]  operand_in,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [PAIR_W-1:0] pair_in,
    input  logic [PAIR_W-1:0] hl_in,
    output logic [ACC_W-1:0]  acc_out,
    output logic [FLAG_W-1:0] flags_out,
    output logic [PAIR_W-1:0] hl_out
);
    alu_op_e           op;
    logic              src_is_acc, pair_is_hl;
    logic [ACC_W-1:0]  b_sel, core_acc;
    logic [FLAG_W-1:0] core_flags;
    logic [PAIR_W-1:0] addend, pair_sum;
    logic              pair_carry;
    logic [ACC_W-1:0]  acc_nxt;
    logic [FLAG_W-1:0] flags_nxt;
    logic [PAIR_W-1:0] hl_nxt;

    acc_alu_decode u_decode (
        .opcode     (opcode),
        .op         (op),
        .src_is_acc (src_is_acc),
        .pair_is_hl (pair_is_hl)
    );

    assign b_sel  = src_is_acc ? acc_in : operand_in;
    assign addend = pair_is_hl ? hl_in : pair_in;

    acc_alu_byte_core u_core (
        .op       (op),
        .a        (acc_in),
        .b        (b_sel),
        .flags_in (flags_in),
        .r_acc    (core_acc),
        .r_flags  (core_flags)
    );

    acc_alu_pair_add u_pair (
        .x     (hl_in),
        .y     (addend),
        .sum   (pair_sum),
        .carry (pair_carry)
    );

    // Merge the 16-bit add result over the byte core outputs
    always_comb begin
        acc_nxt   = core_acc;
        flags_nxt = core_flags;
        hl_nxt    = hl_in;
        if (op == OP_DAD) begin
            hl_nxt          = pair_sum;
            flags_nxt[F_CY] = pair_carry;
        end
    end

    // Output registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out   <= '0;
            flags_out <= '0;
            hl_out    <= '0;
        end else begin
            acc_out   <= acc_nxt;
            flags_out <= flags_nxt;
            hl_out    <= hl_nxt;
        end
    end

    // Reset clears every output register
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && flags_out == '0 && hl_out == '0));

    // Compare, register or immediate, leaves A untouched
    p_cmp_keeps_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[7:3] == 5'b10111 || opcode == 8'hFE) |=> acc_out == $past(acc_in));

    // Logical group clears carry
    p_logic_clears_cy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode[7:6] == 2'b10 || (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b110))
         && opcode[5:3] >= 3'd4 && opcode[5:3] <= 3'd6) |=> !flags_out[F_CY]);

    // Zero flag tracks the written accumulator for non-compare ALU ops
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode[7:6] == 2'b10 || (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b110))
         && opcode[5:3] != 3'd7) |=> flags_out[F_Z] == (acc_out == '0));

    // Rotates touch only carry among the flags
    p_rotate_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[7:5] == 3'b000 && opcode[2:0] == 3'b111)
        |=> flags_out[F_S:F_P] == $past(flags_in[F_S:F_P]));

    // Set carry always yields CY = 1
    p_stc_sets_cy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h37) |=> flags_out[F_CY]);

    // Decimal adjust never clears a set carry
    p_daa_keeps_cy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h27 && flags_in[F_CY]) |=> flags_out[F_CY]);

    // 16-bit add leaves A and the upper flags unchanged
    p_dad_scope_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[7:6] == 2'b00 && opcode[3:0] == 4'h9)
        |=> (acc_out == $past(acc_in) && flags_out[F_S:F_P] == $past(flags_in[F_S:F_P])));
endmodule

// File: tb/acc_alu_unit_bench.sv
// Bench for acc_alu_unit: vector table, directed cases, then a sweep of
// all opcodes against an independent model.
module acc_alu_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;
    localparam int NROWS = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  opcode, acc_in, operand_in;
    logic [4:0]  flags_in;
    logic [15:0] pair_in, hl_in;
    logic [7:0]  acc_out;
    logic [4:0]  flags_out;
    logic [15:0] hl_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu_unit u_acc_alu_unit (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .acc_in(acc_in),
        .operand_in(operand_in), .flags_in(flags_in), .pair_in(pair_in),
        .hl_in(hl_in), .acc_out(acc_out), .flags_out(flags_out), .hl_out(hl_out)
    );

    // Row: {opcode, A, operand, flags in, expected A, expected flags}
    localparam logic [41:0] VEC [NROWS] = '{
        {8'h80, 8'h3A, 8'hC6, 5'h00, 8'h00, 5'h0F},  // R4 R8 add, both carries
        {8'h89, 8'h0F, 8'h00, 5'h01, 8'h10, 5'h04},  // R4 add with carry
        {8'h92, 8'h10, 8'h20, 5'h00, 8'hF0, 5'h17},  // R5 borrow
        {8'h9B, 8'h05, 8'h02, 5'h01, 8'h02, 5'h04},  // R5 borrow-in
        {8'hA4, 8'hF0, 8'h0C, 5'h00, 8'h00, 5'h0E},  // R7 AND sets AC
        {8'hAF, 8'h5A, 8'h33, 5'h01, 8'h00, 5'h0A},  // R2 source is A
        {8'hBD, 8'h40, 8'h40, 5'h00, 8'h40, 5'h0E},  // R6 compare equal
        {8'h07, 8'h81, 8'h00, 5'h00, 8'h03, 5'h01},  // R9 rotate left
        {8'h1F, 8'h01, 8'h00, 5'h1E, 8'h00, 5'h1F},  // R10 rotate right via CY
        {8'h27, 8'h9B, 8'h00, 5'h00, 8'h01, 5'h05},  // R12 both adjusts
        {8'hFE, 8'h00, 8'h01, 5'h00, 8'h00, 5'h13},  // R3 R6 compare immediate
        {8'hF6, 8'h80, 8'h01, 5'h01, 8'h81, 5'h12},  // R3 OR immediate
        {8'h2F, 8'h55, 8'h00, 5'h1F, 8'hAA, 5'h1F},  // R11 complement A
        {8'h37, 8'h12, 8'h00, 5'h00, 8'h12, 5'h01},  // R11 set carry
        {8'h3F, 8'h12, 8'h00, 5'h1F, 8'h12, 5'h1E},  // R11 complement carry
        {8'h00, 8'h77, 8'h00, 5'h15, 8'h77, 5'h15}   // R14 no-op passes
    };
    localparam string ROW_TAG [NROWS] = '{
        "R4", "R4", "R5", "R5", "R7", "R2", "R6", "R9",
        "R10", "R12", "R6", "R3", "R11", "R11", "R11", "R14"
    };

    task automatic check(input string tag, input logic [28:0] got, input logic [28:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got acc=%h flags=%h hl=%h, expected acc=%h flags=%h hl=%h",
                     tag, got[28:21], got[20:16], got[15:0], exp[28:21], exp[20:16], exp[15:0]);
        end
    endtask

    task automatic apply(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [4:0] f, input logic [15:0] pr, input logic [15:0] hl);
        @(negedge clk);
        opcode = op; acc_in = a; operand_in = b; flags_in = f; pair_in = pr; hl_in = hl;
        @(negedge clk);
    endtask

    function automatic int par_even(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    function automatic int flg(input int r, input int h, input int c);
        return (((r >> 7) & 1) << 4) | ((r == 0 ? 1 : 0) << 3) | (h << 2)
             | (par_even(r) << 1) | c;
    endfunction

    // Independent reference: returns {acc, flags, hl}
    function automatic logic [28:0] model(input int opc, input int a, input int b,
                                          input int fl, input int hl, input int pr);
        int cy = fl & 1, acf = (fl >> 2) & 1;
        int grp = opc >> 6, lo3 = opc & 7, mid = (opc >> 3) & 7;
        int r = a, nf = fl, nh = hl;
        int bb, res, c, h, t, hi, s;
        if (grp == 2 || (grp == 3 && lo3 == 6)) begin
            bb = (grp == 2 && lo3 == 7) ? a : b;
            case (mid)
                0, 1: begin
                    c = (mid == 1) ? cy : 0;
                    res = a + bb + c;
                    h = (((a & 15) + (bb & 15) + c) > 15) ? 1 : 0;
                    r = res & 255; nf = flg(r, h, res > 255 ? 1 : 0);
                end
                2, 3, 7: begin
                    c = (mid == 3) ? cy : 0;
                    res = a - bb - c;
                    h = (((a & 15) + (15 - (bb & 15)) + (1 - c)) > 15) ? 1 : 0;
                    nf = flg(res & 255, h, res < 0 ? 1 : 0);
                    r = (mid == 7) ? a : (res & 255);
                end
                4: begin r = a & bb; nf = flg(r, ((a | bb) >> 3) & 1, 0); end
                5: begin r = a ^ bb; nf = flg(r, 0, 0); end
                default: begin r = a | bb; nf = flg(r, 0, 0); end
            endcase
        end else if (grp == 0 && lo3 == 7) begin
            case (mid)
                0: begin r = ((a << 1) | (a >> 7)) & 255; nf = (fl & 30) | (a >> 7); end
                1: begin r = ((a >> 1) | ((a & 1) << 7)); nf = (fl & 30) | (a & 1); end
                2: begin r = ((a << 1) | cy) & 255; nf = (fl & 30) | (a >> 7); end
                3: begin r = (a >> 1) | (cy << 7); nf = (fl & 30) | (a & 1); end
                4: begin
                    t = a; h = 0;
                    if ((a & 15) > 9 || acf == 1) begin
                        h = (((a & 15) + 6) > 15) ? 1 : 0;
                        t = a + 6;
                    end
                    hi = (((t >> 4) & 15) > 9 || cy == 1 || t > 255) ? 1 : 0;
                    r = ((t & 255) + (hi == 1 ? 96 : 0)) & 255;
                    nf = flg(r, h, cy | hi);
                end
                5: r = (~a) & 255;
                6: nf = fl | 1;
                default: nf = fl ^ 1;
            endcase
        end else if (grp == 0 && (opc & 15) == 9) begin
            s = hl + ((((opc >> 4) & 3) == 2) ? hl : pr);
            nh = s & 65535; nf = (fl & 30) | (s > 65535 ? 1 : 0);
        end
        return {8'(r), 5'(nf), 16'(nh)};
    endfunction

    function automatic string tag_of(input int opc);
        if ((opc >> 6) == 2) return "R2";
        if ((opc >> 6) == 3 && (opc & 7) == 6) return "R3";
        if (opc == 8'h07 || opc == 8'h0F) return "R9";
        if (opc == 8'h17 || opc == 8'h1F) return "R10";
        if (opc == 8'h2F || opc == 8'h37 || opc == 8'h3F) return "R11";
        if (opc == 8'h27) return "R12";
        if ((opc >> 6) == 0 && (opc & 15) == 9) return "R13";
        return "R14";
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] corners [4];
        corners = '{8'h00, 8'hFF, 8'h80, 8'h99};
        rst_n = 1'b0;
        opcode = 8'h80; acc_in = 8'h55; operand_in = 8'h11; flags_in = 5'h1F;
        pair_in = 16'h1111; hl_in = 16'hABCD;
        @(negedge clk); @(negedge clk);
        check("R1 reset", {acc_out, flags_out, hl_out}, 29'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            logic [41:0] v;
            v = VEC[i];
            apply(v[41:34], v[33:26], v[25:18], v[17:13], 16'h0000, 16'h1234);
            check(ROW_TAG[i], {acc_out, flags_out, hl_out}, {v[12:5], v[4:0], 16'h1234});
        end

        // R13 carry out of HL
        apply(8'h09, 8'h42, 8'h00, 5'h1E, 16'h8001, 16'h8000);
        check("R13 carry", {acc_out, flags_out, hl_out}, {8'h42, 5'h1F, 16'h0001});
        // R13 HL doubles itself, pair_in ignored
        apply(8'h29, 8'h42, 8'h00, 5'h01, 16'hFFFF, 16'h1234);
        check("R13 hl pair", {acc_out, flags_out, hl_out}, {8'h42, 5'h00, 16'h2468});
        // R13 stack-pair form wraps to zero
        apply(8'h39, 8'h00, 8'h00, 5'h00, 16'h0001, 16'hFFFF);
        check("R13 wrap", {acc_out, flags_out, hl_out}, {8'h00, 5'h01, 16'h0000});
        // R2 add A to itself ignores operand_in
        apply(8'h87, 8'h41, 8'h00, 5'h00, 16'h0, 16'h0);
        check("R2 src acc", {acc_out, flags_out, hl_out}, {8'h82, 5'h12, 16'h0});
        // R12 valid BCD stays put
        apply(8'h27, 8'h99, 8'h00, 5'h00, 16'h0, 16'h0);
        check("R12 bcd", {acc_out, flags_out, hl_out}, {8'h99, 5'h12, 16'h0});
        // R12 incoming carry forces high adjust and is kept
        apply(8'h27, 8'h00, 8'h00, 5'h01, 16'h0, 16'h0);
        check("R12 carry in", {acc_out, flags_out, hl_out}, {8'h60, 5'h03, 16'h0});
        // R14 unrelated opcode passes all state
        apply(8'h76, 8'h3C, 8'h99, 5'h0B, 16'h5555, 16'hBEEF);
        check("R14 pass", {acc_out, flags_out, hl_out}, {8'h3C, 5'h0B, 16'hBEEF});
        // R8 sign and parity on a subtract result
        apply(8'hD6, 8'h00, 8'h01, 5'h00, 16'h0, 16'h0);
        check("R8 sign", {acc_out, flags_out, hl_out}, {8'hFF, 5'h13, 16'h0});

        // Sweep every opcode with corner and random accumulators
        for (int op = 0; op < 256; op++) begin
            for (int k = 0; k < 6; k++) begin
                logic [7:0]  a, b;
                logic [4:0]  f;
                logic [15:0] pr, hl;
                a  = (k < 4) ? corners[k] : 8'($urandom);
                b  = (k == 1) ? corners[3 - k] : 8'($urandom);
                f  = 5'($urandom);
                pr = 16'($urandom);
                hl = 16'($urandom);
                apply(8'(op), a, b, f, pr, hl);
                check(tag_of(op), {acc_out, flags_out, hl_out},
                      model(op, int'(a), int'(b), int'(f), int'(hl), int'(pr)));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule